// File: doc/BRIEF.md
# Interrupt-capable banked GPIO controller

This block controls 24 general-purpose pins, split into three banks of eight, from a byte-wide register bus. Each pin has a direction, a drive or pull mode and a pull direction. Each pin also has an output value that is changed only by write-one-to-set and write-one-to-clear strobes. The synchronized level of every pin can be read back. The pad cell is modelled by four vectors: input level, output value, output enable and pull enable, plus one pull-direction vector.

Any pin can raise an interrupt on a high level, a low level, a rising edge or a falling edge. A pin takes part only if it is individually enabled. Each event latches a per-pin pending bit, which the host clears by writing ones to an acknowledge register. A global source enable gates the single request line. A sticky global pending flag, with its own acknowledge, tells the host that a pin caused the request.

Every per-pin function sits at byte address `4*f + b`, where `f` is the function code and `b` is the bank (0 to 2). Reads return data on `bus_rdata` one cycle after `bus_rd` is sampled.

Top module: `pinbank_irq_ctrl`

## Requirements
- R1: After reset every pin is an input with no pull, all output values are 0, no pin is enabled for interrupts, nothing is pending, the global enable and the global flag are 0, and `irq_out` is 0.
- R2: The function codes are: 0 direction (1 = output), 1 mode, 2 pull direction (1 = up), 3 set (write only), 4 clear (write only), 5 level (read only), 6 interrupt enable, 7 sense (0 = level, 1 = edge), 8 polarity (0 = low/falling, 1 = high/rising), 9 pending (read only), 10 acknowledge (write only). A write reaches only the addressed bank, and `pad_oe` is 1 for an output pin in push-pull mode.
- R3: Writing 1 to a bit of the set register makes that output value 1. Writing 1 to a bit of the clear register makes it 0. Zero bits leave the value unchanged. If both hit one bit in the same cycle, clear wins.
- R4: An output pin in mode 1 (open-drain) drives `pad_out` 0 and enables the driver only while its output value is 0. It releases the pin while the value is 1.
- R5: An input pin in mode 1 asserts `pad_pull_en`, and `pad_pull_up` follows its pull-direction bit. Output pins never assert `pad_pull_en`.
- R6: The level register returns `pad_in` after a two-flop synchronizer, for input and output pins alike.
- R7: A level-sensed enabled pin becomes pending while its synchronized level equals its polarity bit. It is pending again right after an acknowledge if that level persists.
- R8: An edge-sensed enabled pin becomes pending once per matching transition of its synchronized level. The opposite transition does nothing, and an acknowledge clears the bit for good.
- R9: When a matching edge and an acknowledge of that pin fall in the same cycle, the pin stays pending.
- R10: A pin whose interrupt enable is 0 never becomes pending.
- R11: `irq_out` is 1 exactly when the global enable (address 0x30, bit 0) is 1 and at least one enabled pin is pending.
- R12: The global flag (address 0x31, bit 0) is set whenever an enabled pin is pending. It remains set after the pins are acknowledged, until bit 0 is written as 1 at address 0x32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| pad_in | input | 24 | Pin input levels |
| pad_out | output | 24 | Pin output values |
| pad_oe | output | 24 | Pin driver enables |
| pad_pull_en | output | 24 | Pull resistor enables |
| pad_pull_up | output | 24 | Pull direction, 1 = up |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest case to reach is R9. A fresh edge has to land in exactly the cycle in which the host's acknowledge of the same pin is sampled. Only the synchronizer depth links the two from the ports. The bench first leaves the pin pending and idle. It then raises the pin on a falling clock edge, counts two rising edges through the synchronizer and issues the acknowledge write so that it is sampled on the third. If the acknowledge won, the pending bit would read back as 0.

// File: rtl/pinbank_irq_pkg.sv
package pinbank_irq_pkg;
  // function codes: address = (code << bank select width) | bank
  localparam int FN_DIR   = 0;
  localparam int FN_MODE  = 1;
  localparam int FN_PSEL  = 2;
  localparam int FN_SET   = 3;
  localparam int FN_CLR   = 4;
  localparam int FN_LVL   = 5;
  localparam int FN_IEN   = 6;
  localparam int FN_SENSE = 7;
  localparam int FN_POL   = 8;
  localparam int FN_PEND  = 9;
  localparam int FN_ACK   = 10;
  localparam int FN_GLB   = 12;
  // sub-selects inside the global group
  localparam int GSEL_EN   = 0;
  localparam int GSEL_PEND = 1;
  localparam int GSEL_ACK  = 2;
endpackage

// File: rtl/pinbank_pin_sync.sv
module pinbank_pin_sync #(
  parameter int NPIN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] lvl_prev_o
);
  logic [NPIN-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o      = lvl_q;
  assign lvl_prev_o = prev_q;
endmodule

// File: rtl/pinbank_irq_detect.sv
module pinbank_irq_detect #(
  parameter int NPIN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] lvl_prev_i,
  input  logic [NPIN-1:0] ien_i,
  input  logic [NPIN-1:0] sense_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] ack_i,
  input  logic            gen_i,
  input  logic            gack_i,
  output logic [NPIN-1:0] pend_o,
  output logic            gpend_o,
  output logic            irq_o
);
  logic [NPIN-1:0] pend_q, pend_d, hit;
  logic            gpend_q, gpend_d, act;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      logic lvl_hit, edge_hit;
      lvl_hit  = (lvl_i[i] == pol_i[i]);
      edge_hit = pol_i[i] ? (lvl_i[i] & ~lvl_prev_i[i])
                          : (~lvl_i[i] & lvl_prev_i[i]);
      hit[i]   = ien_i[i] & (sense_i[i] ? edge_hit : lvl_hit);
    end
    // a fresh event outranks an acknowledge in the same cycle
    pend_d  = (pend_q & ~ack_i) | hit;
    act     = |(pend_q & ien_i);
    gpend_d = (gpend_q & ~gack_i) | act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      gpend_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      gpend_q <= gpend_d;
    end
  end

  assign pend_o  = pend_q;
  assign gpend_o = gpend_q;
  assign irq_o   = gen_i & act;
endmodule

// File: rtl/pinbank_ctrl_regs.sv
module pinbank_ctrl_regs
  import pinbank_irq_pkg::*;
#(
  parameter int NBANK  = 3,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BANK_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [BANK_W-1:0]       bus_rdata,
  input  logic [NBANK*BANK_W-1:0] lvl_i,
  input  logic [NBANK*BANK_W-1:0] pend_i,
  input  logic                    gpend_i,
  output logic [NBANK*BANK_W-1:0] dir_o,
  output logic [NBANK*BANK_W-1:0] mode_o,
  output logic [NBANK*BANK_W-1:0] psel_o,
  output logic [NBANK*BANK_W-1:0] out_o,
  output logic [NBANK*BANK_W-1:0] ien_o,
  output logic [NBANK*BANK_W-1:0] sense_o,
  output logic [NBANK*BANK_W-1:0] pol_o,
  output logic [NBANK*BANK_W-1:0] ack_o,
  output logic                    gen_o,
  output logic                    gack_o
);
  localparam int NPIN   = NBANK * BANK_W;
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int FN_W   = ADDR_W - BSEL_W;

  logic [FN_W-1:0]   fn;
  logic [BSEL_W-1:0] bsel;
  logic [NPIN-1:0]   dir_q, mode_q, psel_q, out_q, ien_q, sense_q, pol_q;
  logic [NPIN-1:0]   dir_d, mode_d, psel_d, out_d, ien_d, sense_d, pol_d;
  logic [NPIN-1:0]   set_m, clr_m, ack_m;
  logic              gen_q, gen_d, gack;
  logic [BANK_W-1:0] rd_d, rdata_q;

  assign fn   = bus_addr[ADDR_W-1:BSEL_W];
  assign bsel = bus_addr[BSEL_W-1:0];

  // write decode and next state
  always_comb begin
    dir_d   = dir_q;
    mode_d  = mode_q;
    psel_d  = psel_q;
    ien_d   = ien_q;
    sense_d = sense_q;
    pol_d   = pol_q;
    gen_d   = gen_q;
    set_m   = '0;
    clr_m   = '0;
    ack_m   = '0;
    gack    = 1'b0;
    if (bus_wr) begin
      if (int'(fn) == FN_GLB) begin
        if (int'(bsel) == GSEL_EN)  gen_d = bus_wdata[0];
        if (int'(bsel) == GSEL_ACK) gack  = bus_wdata[0];
      end
      for (int b = 0; b < NBANK; b++) begin
        if (int'(bsel) == b) begin
          case (int'(fn))
            FN_DIR:   dir_d[b*BANK_W +: BANK_W]   = bus_wdata;
            FN_MODE:  mode_d[b*BANK_W +: BANK_W]  = bus_wdata;
            FN_PSEL:  psel_d[b*BANK_W +: BANK_W]  = bus_wdata;
            FN_SET:   set_m[b*BANK_W +: BANK_W]   = bus_wdata;
            FN_CLR:   clr_m[b*BANK_W +: BANK_W]   = bus_wdata;
            FN_IEN:   ien_d[b*BANK_W +: BANK_W]   = bus_wdata;
            FN_SENSE: sense_d[b*BANK_W +: BANK_W] = bus_wdata;
            FN_POL:   pol_d[b*BANK_W +: BANK_W]   = bus_wdata;
            FN_ACK:   ack_m[b*BANK_W +: BANK_W]   = bus_wdata;
            default: ;
          endcase
        end
      end
    end
    // clear has priority over set
    out_d = (out_q | set_m) & ~clr_m;
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (int'(fn) == FN_GLB) begin
      if (int'(bsel) == GSEL_EN)   rd_d[0] = gen_q;
      if (int'(bsel) == GSEL_PEND) rd_d[0] = gpend_i;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (int'(bsel) == b) begin
        case (int'(fn))
          FN_DIR:   rd_d = dir_q[b*BANK_W +: BANK_W];
          FN_MODE:  rd_d = mode_q[b*BANK_W +: BANK_W];
          FN_PSEL:  rd_d = psel_q[b*BANK_W +: BANK_W];
          FN_LVL:   rd_d = lvl_i[b*BANK_W +: BANK_W];
          FN_IEN:   rd_d = ien_q[b*BANK_W +: BANK_W];
          FN_SENSE: rd_d = sense_q[b*BANK_W +: BANK_W];
          FN_POL:   rd_d = pol_q[b*BANK_W +: BANK_W];
          FN_PEND:  rd_d = pend_i[b*BANK_W +: BANK_W];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      mode_q  <= '0;
      psel_q  <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      gen_q   <= 1'b0;
    end else if (bus_wr) begin
      dir_q   <= dir_d;
      mode_q  <= mode_d;
      psel_q  <= psel_d;
      out_q   <= out_d;
      ien_q   <= ien_d;
      sense_q <= sense_d;
      pol_q   <= pol_d;
      gen_q   <= gen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
  assign dir_o     = dir_q;
  assign mode_o    = mode_q;
  assign psel_o    = psel_q;
  assign out_o     = out_q;
  assign ien_o     = ien_q;
  assign sense_o   = sense_q;
  assign pol_o     = pol_q;
  assign ack_o     = ack_m;
  assign gen_o     = gen_q;
  assign gack_o    = gack;
endmodule

// File: rtl/pinbank_irq_ctrl.sv
module pinbank_irq_ctrl #(
  parameter int NBANK  = 3,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BANK_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [BANK_W-1:0]       bus_rdata,
  input  logic [NBANK*BANK_W-1:0] pad_in,
  output logic [NBANK*BANK_W-1:0] pad_out,
  output logic [NBANK*BANK_W-1:0] pad_oe,
  output logic [NBANK*BANK_W-1:0] pad_pull_en,
  output logic [NBANK*BANK_W-1:0] pad_pull_up,
  output logic                    irq_out
);
  localparam int NPIN = NBANK * BANK_W;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [NPIN-1:0] lvl, lvl_prev, pend_q;
  logic [NPIN-1:0] dir_q, mode_q, psel_q, out_q, ien_q, sense_q, pol_q, ack_m;
  logic            gen_q, gack, gpend_q;

  pinbank_pin_sync #(.NPIN(NPIN)) u_sync (
    .clk        (clk),
    .rst_n      (srst_n),
    .pin_i      (pad_in),
    .lvl_o      (lvl),
    .lvl_prev_o (lvl_prev)
  );

  pinbank_ctrl_regs #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .lvl_i     (lvl),
    .pend_i    (pend_q),
    .gpend_i   (gpend_q),
    .dir_o     (dir_q),
    .mode_o    (mode_q),
    .psel_o    (psel_q),
    .out_o     (out_q),
    .ien_o     (ien_q),
    .sense_o   (sense_q),
    .pol_o     (pol_q),
    .ack_o     (ack_m),
    .gen_o     (gen_q),
    .gack_o    (gack)
  );

  pinbank_irq_detect #(.NPIN(NPIN)) u_det (
    .clk        (clk),
    .rst_n      (srst_n),
    .lvl_i      (lvl),
    .lvl_prev_i (lvl_prev),
    .ien_i      (ien_q),
    .sense_i    (sense_q),
    .pol_i      (pol_q),
    .ack_i      (ack_m),
    .gen_i      (gen_q),
    .gack_i     (gack),
    .pend_o     (pend_q),
    .gpend_o    (gpend_q),
    .irq_o      (irq_out)
  );

  // pad mapping: mode bit is open-drain for outputs, pull enable for inputs
  assign pad_out     = out_q & ~mode_q;
  assign pad_oe      = dir_q & ~(mode_q & out_q);
  assign pad_pull_en = ~dir_q & mode_q;
  assign pad_pull_up = ~dir_q & mode_q & psel_q;
endmodule

// File: rtl/pinbank_irq_ctrl_chk.sv
module pinbank_irq_ctrl_chk
  import pinbank_irq_pkg::*;
#(
  parameter int NBANK  = 3,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 8
) (
  input logic                    clk,
  input logic                    srst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [BANK_W-1:0]       bus_wdata,
  input logic                    bus_wr,
  input logic [NBANK*BANK_W-1:0] out_q,
  input logic [NBANK*BANK_W-1:0] dir_q,
  input logic [NBANK*BANK_W-1:0] mode_q,
  input logic [NBANK*BANK_W-1:0] ien_q,
  input logic [NBANK*BANK_W-1:0] pend_q,
  input logic [NBANK*BANK_W-1:0] pad_out,
  input logic                    gen_q,
  input logic                    gpend_q,
  input logic                    irq_out
);
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(FN_SET << BSEL_W);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(FN_CLR << BSEL_W);

  // R3: ones written to the set register appear in the output value
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_SET0) |=>
      ((out_q[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: ones written to the clear register drop from the output value
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_CLR0) |=>
      ((out_q[BANK_W-1:0] & $past(bus_wdata)) == '0));

  // R4: an open-drain output never drives high
  p_od_no_high_r4: assert property (@(posedge clk) disable iff (!srst_n)
    ((pad_out & mode_q & dir_q) == '0));

  // R10: a bit only becomes pending if it was enabled the cycle before
  p_pend_needs_en_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ((pend_q & ~$past(pend_q) & ~$past(ien_q)) == '0));

  // R11: no request without the global enable
  p_gate_global_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !gen_q |-> !irq_out);

  // R11: no request without an enabled pending pin
  p_gate_pin_r11: assert property (@(posedge clk) disable iff (!srst_n)
    ((pend_q & ien_q) == '0) |-> !irq_out);

  // R12: an enabled pending pin sets the global flag
  p_gflag_r12: assert property (@(posedge clk) disable iff (!srst_n)
    (|(pend_q & ien_q)) |=> gpend_q);
endmodule

bind pinbank_irq_ctrl pinbank_irq_ctrl_chk #(
  .NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .out_q     (out_q),
  .dir_q     (dir_q),
  .mode_q    (mode_q),
  .ien_q     (ien_q),
  .pend_q    (pend_q),
  .pad_out   (pad_out),
  .gen_q     (gen_q),
  .gpend_q   (gpend_q),
  .irq_out   (irq_out)
);

// File: tb/sim_pinbank_irq_ctrl.sv
module sim_pinbank_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  // addresses from the R2 map: 4*code + bank
  localparam logic [7:0] A_DIR0 = 8'h00, A_DIR1 = 8'h01, A_DIR2 = 8'h02;
  localparam logic [7:0] A_MODE0 = 8'h04, A_MODE1 = 8'h05;
  localparam logic [7:0] A_PSEL1 = 8'h09;
  localparam logic [7:0] A_SET0 = 8'h0C, A_SET2 = 8'h0E, A_CLR0 = 8'h10;
  localparam logic [7:0] A_LVL1 = 8'h15, A_LVL2 = 8'h16;
  localparam logic [7:0] A_IEN1 = 8'h19, A_SNS1 = 8'h1D, A_POL1 = 8'h21;
  localparam logic [7:0] A_PEND1 = 8'h25, A_PEND2 = 8'h26, A_ACK1 = 8'h29;
  localparam logic [7:0] A_GEN = 8'h30, A_GPEND = 8'h31, A_GACK = 8'h32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [23:0] pad_in = '0, pad_out, pad_oe, pad_pull_en, pad_pull_up;
  logic        irq_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pull_en", pad_pull_en, 0);
    chk("R1 irq_out", irq_out, 0);
    rd(A_DIR0, d);  chk("R1 dir0", d, 0);
    rd(A_PEND2, d); chk("R1 pend2", d, 0);
    rd(A_GEN, d);   chk("R1 gen", d, 0);
    rd(A_GPEND, d); chk("R1 gflag", d, 0);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    wr(A_DIR0, 8'hFF);
    wr(A_SET0, 8'hA5);
    chk("R2 oe bank0", pad_oe[7:0], 8'hFF);
    chk("R3 set", pad_out[7:0], 8'hA5);
    wr(A_CLR0, 8'h05);
    chk("R3 clear", pad_out[7:0], 8'hA0);
    wr(A_SET0, 8'h00);
    chk("R3 zero set no effect", pad_out[7:0], 8'hA0);
    wr(A_CLR0, 8'h00);
    chk("R3 zero clear no effect", pad_out[7:0], 8'hA0);
    wr(A_DIR2, 8'h0F);
    wr(A_SET2, 8'h03);
    chk("R2 oe bank2", pad_oe[23:16], 8'h0F);
    chk("R2 out bank2", pad_out[23:16], 8'h03);
    chk("R2 bank1 untouched", {pad_oe[15:8], pad_out[15:8]}, 0);
    rd(A_DIR0, d); chk("R2 dir0 readback", d, 8'hFF);
  endtask

  task automatic t_open_drain();
    // bank0 out = A0; bits 7:4 open-drain
    wr(A_MODE0, 8'hF0);
    chk("R4 od out low", pad_out[7:0], 8'h00);
    chk("R4 od oe", pad_oe[7:0], 8'h5F);
    wr(A_SET0, 8'h10);
    chk("R4 od release", pad_oe[7:0], 8'h4F);
    chk("R5 no pull on outputs", pad_pull_en[7:0], 8'h00);
  endtask

  task automatic t_pull();
    wr(A_MODE1, 8'h0F);
    wr(A_PSEL1, 8'h03);
    chk("R5 pull_en", pad_pull_en[15:8], 8'h0F);
    chk("R5 pull_up", pad_pull_up[15:8], 8'h03);
    wr(A_MODE1, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    pad_in = 24'h3C5A00;
    settle();
    rd(A_LVL1, d); chk("R6 level bank1", d, 8'h5A);
    rd(A_LVL2, d); chk("R6 level bank2 output pins", d, 8'h3C);
    pad_in = '0;
    settle();
  endtask

  task automatic t_level_irq();
    logic [7:0] d;
    // pin8 high-level, pin9 low-level
    wr(A_SNS1, 8'h00);
    wr(A_POL1, 8'h01);
    wr(A_IEN1, 8'h03);
    settle();
    rd(A_PEND1, d); chk("R7 low level pends", d, 8'h02);
    pad_in[8] = 1'b1;
    settle();
    rd(A_PEND1, d); chk("R7 high level pends", d, 8'h03);
    wr(A_ACK1, 8'h03);
    rd(A_PEND1, d); chk("R7 re-pend while held", d, 8'h03);
    pad_in[8] = 1'b0; pad_in[9] = 1'b1;
    settle();
    wr(A_ACK1, 8'h03);
    rd(A_PEND1, d); chk("R7 cleared when inactive", d, 8'h00);
    wr(A_IEN1, 8'h00);
    pad_in[9] = 1'b0;
  endtask

  task automatic t_edge_irq();
    logic [7:0] d;
    // pin10 rising, pin11 falling
    pad_in[11] = 1'b1;
    wr(A_SNS1, 8'h0C);
    wr(A_POL1, 8'h04);
    settle();
    wr(A_IEN1, 8'h0C);
    settle();
    rd(A_PEND1, d); chk("R8 idle edge pins", d, 8'h00);
    pad_in[10] = 1'b1;
    settle();
    rd(A_PEND1, d); chk("R8 rising edge", d, 8'h04);
    wr(A_ACK1, 8'h04);
    settle();
    rd(A_PEND1, d); chk("R8 ack clears edge", d, 8'h00);
    pad_in[11] = 1'b0;
    settle();
    rd(A_PEND1, d); chk("R8 falling edge", d, 8'h08);
    pad_in[10] = 1'b0;
    settle();
    rd(A_PEND1, d); chk("R8 opposite edge ignored", d, 8'h08);
    wr(A_ACK1, 8'h08);
    rd(A_PEND1, d); chk("R8 ack falling", d, 8'h00);
  endtask

  task automatic t_edge_ack_race();
    logic [7:0] d;
    pad_in[10] = 1'b1; settle();
    pad_in[10] = 1'b0; settle();
    // pin10 pending and low; rise now, ack sampled on the third rising edge
    pad_in[10] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(A_ACK1, 8'h04);
    rd(A_PEND1, d); chk("R9 edge beats ack", d, 8'h04);
    wr(A_ACK1, 8'h04);
    rd(A_PEND1, d); chk("R9 later ack clears", d, 8'h00);
    wr(A_IEN1, 8'h00);
    pad_in[10] = 1'b0;
    settle();
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(A_SNS1, 8'h00);
    wr(A_POL1, 8'h10);
    pad_in[12] = 1'b1;
    settle();
    rd(A_PEND1, d); chk("R10 disabled pin not pending", d, 8'h00);
    chk("R10 no irq", irq_out, 0);
    pad_in[12] = 1'b0;
    settle();
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(A_POL1, 8'h01);
    wr(A_IEN1, 8'h01);
    pad_in[8] = 1'b1;
    settle();
    chk("R11 held off by global enable", irq_out, 0);
    rd(A_GPEND, d); chk("R12 flag set", d, 8'h01);
    wr(A_GEN, 8'h01);
    chk("R11 request asserted", irq_out, 1);
    pad_in[8] = 1'b0;
    settle();
    wr(A_ACK1, 8'h01);
    chk("R11 request dropped", irq_out, 0);
    rd(A_GPEND, d); chk("R12 flag sticky", d, 8'h01);
    wr(A_GACK, 8'h01);
    rd(A_GPEND, d); chk("R12 flag acknowledged", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_outputs();
    t_open_drain();
    t_pull();
    t_level();
    t_level_irq();
    t_edge_irq();
    t_edge_ack_race();
    t_disabled();
    t_gate();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule